// File: doc/BRIEF.md
# Dual-Bit SPI Byte Shifter

This block is the host side of an SPI link. It takes bytes one at a time over a valid/ready interface and shifts each one out in one of two ways. The first way puts one bit on each SCK clock over eight clocks. The second way puts two bits on each clock over four clocks, using a second output line. The mode is chosen per byte. In one-bit mode the block also captures a byte from the slave and hands it back with a one-cycle valid strobe.

The SCK rate comes from a divisor field. One SCK period lasts 2 × (divisor + 1) system clocks. A divisor of zero is not allowed and is raised to one. The block drives up to `NUM_CS` chip-select lines, and each line has its own polarity.

A transfer is a run of bytes that ends with a byte marked last. When that byte is also marked hold, the chip select stays asserted, and the next transfer continues the same frame on the same device. Otherwise the select is released and the block waits a short fixed gap before it accepts the next byte.

Top module: `dspi_master`

## Requirements
- R1: The effective divisor is `cfg_div`, or 1 when `cfg_div` is 0. It is sampled only when the first byte of a transfer is accepted. Changes to `cfg_div` during a transfer have no effect on the SCK rate until the next transfer begins.
- R2: SCK idles low. For each clock, SCK stays low for divisor+1 cycles after the data is set up, then stays high for divisor+1 cycles. One SCK period is therefore 2 × (divisor + 1) system clocks.
- R3: A byte with `tx_dual`=0 produces eight SCK clocks, most significant bit first, on `mosi`. Data changes only while SCK is low and is stable while SCK is high.
- R4: A byte with `tx_dual`=1 produces four SCK clocks. On each clock `mosi` carries bit 7, 5, 3, 1 in turn and `mosi_aux` carries bit 6, 4, 2, 0 in turn. No received byte is reported for such a byte.
- R5: In one-bit mode `miso` is sampled at each SCK rise and shifted in, most significant bit first. One cycle after the eighth clock's high phase ends, `rx_valid` pulses for exactly one cycle with the byte on `rx_data`.
- R6: A byte with `tx_blank`=1 shifts out zeros, whatever `tx_data` holds.
- R7: The first byte accepted while idle latches `cs_sel` (values 0 to NUM_CS-1). Exactly that line asserts on the edge that accepts the byte. A line is active low when its `cs_pol_hi` bit is 0 and active high when that bit is 1. Every other line sits at its inactive level.
- R8: After a byte without `tx_last`, or a `tx_last` byte with `tx_hold`=1, the chip select stays asserted and `tx_ready` is high. Bytes that follow use the held device and ignore `cs_sel`. A byte that follows a held `tx_last` byte starts a new transfer, and the divisor is latched again.
- R9: After a `tx_last` byte with `tx_hold`=0, the chip select is released on the edge where its final SCK falls. `tx_ready` then stays low for exactly `GAP_CYC` cycles before the block is idle again.
- R10: `busy` rises on the edge that accepts the first byte and falls on the edge that releases the chip select. It is high exactly while a chip select is asserted.
- R11: During and just after reset, `sck`, `mosi`, `mosi_aux`, `busy` and `rx_valid` are 0. Every chip-select line is at its inactive level, and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | SCK divisor field (0 is treated as 1) |
| cs_sel | input | SEL_W | Device index, latched at the first byte |
| cs_pol_hi | input | NUM_CS | Per-line polarity: 1 means active high |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Block can take a byte |
| tx_data | input | 8 | Byte to send |
| tx_dual | input | 1 | Two bits per clock for this byte |
| tx_blank | input | 1 | Send zeros instead of tx_data |
| tx_last | input | 1 | Final byte of the transfer |
| tx_hold | input | 1 | With tx_last, keep the select asserted |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Main data out |
| mosi_aux | output | 1 | Second data out, used in dual mode |
| miso | input | 1 | Serial data in |
| cs_line | output | NUM_CS | Chip-select pins at their physical levels |
| busy | output | 1 | A select is asserted |

## Verification
The assertions assume two things about the inputs. First, `cs_sel` names an existing device whenever a transfer starts. Second, `cs_pol_hi` changes only while the block is idle, because the checks on the high-phase length and the select tracking rely on the divisor and the device being fixed for a whole frame. The stimulus only ever picks devices 0 to 2, and changes polarity only between transfers. It moves `cfg_div` in the middle of a frame only to show that the latched value wins. The slave model in the bench returns a known pattern on `miso`, and it shifts that pattern on SCK edges the way a mode-0 slave would.

// File: rtl/dspi_pkg.sv
package dspi_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_WAIT  = 2'd2,
    ST_GAP   = 2'd3
  } dspi_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       dual;
    logic       blank;
  } dspi_byte_t;

endpackage

// File: rtl/dspi_sck_gen.sv
module dspi_sck_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise_evt,
  output logic             fall_evt
);

  logic [DIV_W-1:0] cnt;
  logic             half;
  logic             at_end;

  assign at_end   = (cnt == div);
  assign rise_evt = run && !half && at_end;
  assign fall_evt = run && half && at_end;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt  <= '0;
      half <= 1'b0;
      sck  <= 1'b0;
    end else if (run) begin
      if (at_end) begin
        cnt  <= '0;
        half <= ~half;
        sck  <= ~half;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Length of the current high phase, saturating.
  logic [DIV_W:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst || !sck)
      hi_len <= '0;
    else if (hi_len != {(DIV_W+1){1'b1}})
      hi_len <= hi_len + 1'b1;
  end

  // R2: every high phase lasts divisor+1 cycles
  a_r2_high_len: assert property (@(posedge clk) disable iff (rst)
    $fell(sck) |-> ($past(hi_len) == {1'b0, div}));

endmodule

// File: rtl/dspi_shift_eng.sv
module dspi_shift_eng
  import dspi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  dspi_byte_t ld_byte,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic       miso,
  output logic       mosi,
  output logic       mosi_aux,
  output logic       byte_done,
  output logic       rx_valid,
  output logic [7:0] rx_data
);

  logic [7:0] sh;
  logic [7:0] sh_nxt;
  logic [7:0] rx_sh;
  logic [7:0] ld_val;
  logic [2:0] bits;
  logic       dual_q;
  logic       last_bit;

  assign ld_val    = ld_byte.blank ? 8'h00 : ld_byte.data;
  assign last_bit  = dual_q ? (bits == 3'd3) : (bits == 3'd7);
  assign byte_done = fall_evt && last_bit;

  always_comb begin
    if (dual_q) sh_nxt = {sh[5:0], 2'b00};
    else        sh_nxt = {sh[6:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      rx_sh    <= '0;
      bits     <= '0;
      dual_q   <= 1'b0;
      mosi     <= 1'b0;
      mosi_aux <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (load) begin
        sh       <= ld_val;
        bits     <= '0;
        dual_q   <= ld_byte.dual;
        mosi     <= ld_val[7];
        mosi_aux <= ld_byte.dual ? ld_val[6] : 1'b0;
      end else begin
        if (rise_evt)
          rx_sh <= {rx_sh[6:0], miso};
        if (fall_evt) begin
          if (last_bit) begin
            mosi     <= 1'b0;
            mosi_aux <= 1'b0;
            rx_valid <= !dual_q;
            rx_data  <= rx_sh;
          end else begin
            sh       <= sh_nxt;
            bits     <= bits + 1'b1;
            mosi     <= sh_nxt[7];
            mosi_aux <= dual_q ? sh_nxt[6] : 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/dspi_cs_ctl.sv
module dspi_cs_ctl #(
  parameter int NUM_CS = 3,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set,
  input  logic              clr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_CS-1:0] pol_hi,
  output logic [NUM_CS-1:0] cs_line,
  output logic [NUM_CS-1:0] cs_act
);

  logic             on_q, on_n;
  logic [SEL_W-1:0] idx_q, idx_n;

  always_comb begin
    on_n  = on_q;
    idx_n = idx_q;
    if (set) begin
      on_n  = 1'b1;
      idx_n = sel;
    end else if (clr) begin
      on_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      on_q  <= on_n;
      idx_q <= idx_n;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic act_n;
    assign act_n = on_n && (idx_n == SEL_W'(i));
    always_ff @(posedge clk) begin
      if (rst) begin
        cs_act[i]  <= 1'b0;
        cs_line[i] <= ~pol_hi[i];
      end else begin
        cs_act[i]  <= act_n;
        cs_line[i] <= act_n ^ ~pol_hi[i];
      end
    end
  end

endmodule

// File: rtl/dspi_master.sv
module dspi_master
  import dspi_pkg::*;
#(
  parameter int NUM_CS  = 3,
  parameter int DIV_W   = 6,
  parameter int GAP_CYC = 4,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [SEL_W-1:0]  cs_sel,
  input  logic [NUM_CS-1:0] cs_pol_hi,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [7:0]        tx_data,
  input  logic              tx_dual,
  input  logic              tx_blank,
  input  logic              tx_last,
  input  logic              tx_hold,
  output logic              rx_valid,
  output logic [7:0]        rx_data,
  output logic              sck,
  output logic              mosi,
  output logic              mosi_aux,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_line,
  output logic              busy
);

  localparam int GAP_W = $clog2(GAP_CYC + 1);

  dspi_state_e       st;
  logic [DIV_W-1:0]  div_q;
  logic [DIV_W-1:0]  div_eff;
  logic [GAP_W-1:0]  gap_cnt;
  logic              last_q, hold_q, newx_q;
  logic              accept, start_xfer, cs_set, release_cs;
  logic              byte_done, rise_evt, fall_evt;
  logic [NUM_CS-1:0] cs_act;
  dspi_byte_t        in_byte;

  assign tx_ready   = (st == ST_IDLE) || (st == ST_WAIT);
  assign accept     = tx_valid && tx_ready;
  assign cs_set     = accept && (st == ST_IDLE);
  assign start_xfer = accept && ((st == ST_IDLE) || newx_q);
  assign release_cs = byte_done && last_q && !hold_q;
  assign div_eff    = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  assign in_byte    = '{data: tx_data, dual: tx_dual, blank: tx_blank};

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      div_q   <= DIV_W'(1);
      gap_cnt <= '0;
      last_q  <= 1'b0;
      hold_q  <= 1'b0;
      newx_q  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      if (start_xfer)
        div_q <= div_eff;
      case (st)
        ST_IDLE, ST_WAIT: begin
          if (accept) begin
            st     <= ST_SHIFT;
            last_q <= tx_last;
            hold_q <= tx_hold;
            newx_q <= 1'b0;
            busy   <= 1'b1;
          end
        end
        ST_SHIFT: begin
          if (byte_done) begin
            if (release_cs) begin
              st      <= ST_GAP;
              gap_cnt <= '0;
              busy    <= 1'b0;
            end else begin
              st     <= ST_WAIT;
              newx_q <= last_q;
            end
          end
        end
        default: begin
          if (gap_cnt == GAP_W'(GAP_CYC - 1))
            st <= ST_IDLE;
          else
            gap_cnt <= gap_cnt + 1'b1;
        end
      endcase
    end
  end

  dspi_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .run      (st == ST_SHIFT),
    .div      (div_q),
    .sck      (sck),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  dspi_shift_eng u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .ld_byte   (in_byte),
    .rise_evt  (rise_evt),
    .fall_evt  (fall_evt),
    .miso      (miso),
    .mosi      (mosi),
    .mosi_aux  (mosi_aux),
    .byte_done (byte_done),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data)
  );

  dspi_cs_ctl #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .clk     (clk),
    .rst     (rst),
    .set     (cs_set),
    .clr     (release_cs),
    .sel     (cs_sel),
    .pol_hi  (cs_pol_hi),
    .cs_line (cs_line),
    .cs_act  (cs_act)
  );

  // R2: no clock activity while idle
  a_r2_idle_sck_low: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sck);

  // R3: data lines hold still through a high phase
  a_r3_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> ($stable(mosi) && $stable(mosi_aux)));

  // R10: busy mirrors the asserted select
  a_r10_busy_tracks_cs: assert property (@(posedge clk) disable iff (rst)
    busy == (|cs_act));

  // R9: no byte is taken right after a release
  a_r9_gap_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !tx_ready);

endmodule

// File: tb/test_dspi_master.sv
`timescale 1ns/1ps
module test_dspi_master;

  localparam int NUM_CS  = 3;
  localparam int DIV_W   = 6;
  localparam int GAP_CYC = 4;
  localparam int SEL_W   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DIV_W-1:0]  cfg_div = '0;
  logic [SEL_W-1:0]  cs_sel = '0;
  logic [NUM_CS-1:0] cs_pol_hi = '0;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic [7:0]        tx_data = '0;
  logic              tx_dual = 1'b0, tx_blank = 1'b0, tx_last = 1'b0, tx_hold = 1'b0;
  logic              rx_valid;
  logic [7:0]        rx_data;
  logic              sck, mosi, mosi_aux, miso;
  logic [NUM_CS-1:0] cs_line;
  logic              busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // slave model state
  int         rises = 0;
  logic [7:0] cap_main = '0, cap_aux = '0;
  logic [7:0] pat = '0;
  longint     rt0 = 0, rt1 = 0;
  int         rx_cnt = 0;
  logic [7:0] rx_last = '0;

  always #4 clk = ~clk;

  dspi_master #(.NUM_CS(NUM_CS), .DIV_W(DIV_W), .GAP_CYC(GAP_CYC), .SEL_W(SEL_W)) i_dspi_master (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cs_sel(cs_sel), .cs_pol_hi(cs_pol_hi),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_dual(tx_dual),
    .tx_blank(tx_blank), .tx_last(tx_last), .tx_hold(tx_hold), .rx_valid(rx_valid),
    .rx_data(rx_data), .sck(sck), .mosi(mosi), .mosi_aux(mosi_aux), .miso(miso),
    .cs_line(cs_line), .busy(busy)
  );

  assign miso = (rises < 8) ? pat[3'(7 - rises)] : 1'b0;

  always @(posedge sck) begin
    if (rises == 0) rt0 = $time;
    if (rises == 1) rt1 = $time;
    cap_main = {cap_main[6:0], mosi};
    cap_aux  = {cap_aux[6:0], mosi_aux};
    rises    = rises + 1;
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt  = rx_cnt + 1;
      rx_last = rx_data;
    end
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles, expected < 150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic ok, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual 0x%0h, expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic dual, input logic blank,
                      input logic last, input logic hold, input logic [SEL_W-1:0] sel);
    @(negedge clk);
    rises = 0; cap_main = '0; cap_aux = '0;
    tx_data = d; tx_dual = dual; tx_blank = blank; tx_last = last; tx_hold = hold;
    cs_sel = sel; tx_valid = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      @(posedge clk);
      if (tx_ready) break;
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_first_rise();
    for (int i = 0; i < 1000; i++) begin
      if (rises >= 1) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_done(output int gapc);
    gapc = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (tx_ready) break;
      if (!busy) gapc++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 sck", sck == 1'b0, sck, 0);
    chk("R11 mosi", (mosi | mosi_aux) == 1'b0, {mosi, mosi_aux}, 0);
    chk("R11 cs", cs_line == 3'b111, cs_line, 3'b111);
    chk("R11 busy/ready", !busy && tx_ready && !rx_valid, {busy, tx_ready}, 2'b01);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_single();
    int g; int rx0;
    cfg_div = 6'd2; pat = 8'h3C; rx0 = rx_cnt;
    send(8'hA5, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    wait_first_rise();
    chk("R7 cs0 asserted", cs_line == 3'b110, cs_line, 3'b110);
    chk("R10 busy high", busy == 1'b1, busy, 1);
    wait_done(g);
    chk("R3 single byte", cap_main == 8'hA5 && rises == 8, cap_main, 8'hA5);
    chk("R5 rx byte", rx_cnt == rx0 + 1 && rx_last == 8'h3C, rx_last, 8'h3C);
    chk("R2 period div2", (rt1 - rt0) == 48, rt1 - rt0, 48);
    chk("R9 gap length", g == GAP_CYC, g, GAP_CYC);
    chk("R9 cs released", cs_line == 3'b111 && !busy, cs_line, 3'b111);
  endtask

  task automatic t_dual();
    int g; int rx0; logic [7:0] d; logic [3:0] em, ea;
    d = 8'h9C; rx0 = rx_cnt;
    for (int k = 0; k < 4; k++) begin
      em[3-k] = d[7-2*k];
      ea[3-k] = d[6-2*k];
    end
    cfg_div = 6'd1;
    send(d, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0);
    wait_done(g);
    chk("R4 clock count", rises == 4, rises, 4);
    chk("R4 main line", cap_main[3:0] == em, cap_main[3:0], em);
    chk("R4 aux line", cap_aux[3:0] == ea, cap_aux[3:0], ea);
    chk("R4 no rx", rx_cnt == rx0, rx_cnt, rx0);
    chk("R2 period div1", (rt1 - rt0) == 32, rt1 - rt0, 32);
  endtask

  task automatic t_div_zero();
    int g;
    cfg_div = 6'd0;
    send(8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    wait_done(g);
    chk("R1 zero divisor forced to 1", (rt1 - rt0) == 32, rt1 - rt0, 32);
    chk("R3 byte at div0", cap_main == 8'h5A, cap_main, 8'h5A);
  endtask

  task automatic t_blank();
    int g;
    cfg_div = 6'd1;
    send(8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0);
    wait_done(g);
    chk("R6 zeros sent", cap_main == 8'h00 && rises == 8, cap_main, 0);
  endtask

  task automatic t_hold();
    int g;
    cfg_div = 6'd3;
    send(8'h81, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2);
    wait_done(g);
    repeat (3) @(negedge clk);
    chk("R8 cs held", cs_line == 3'b011, cs_line, 3'b011);
    chk("R8 busy and ready", busy && tx_ready, {busy, tx_ready}, 2'b11);
    cfg_div = 6'd1;
    send(8'h42, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    wait_first_rise();
    chk("R8 sel ignored", cs_line == 3'b011, cs_line, 3'b011);
    wait_done(g);
    chk("R8 new divisor latched", (rt1 - rt0) == 32, rt1 - rt0, 32);
    chk("R8 byte continued", cap_main == 8'h42, cap_main, 8'h42);
    chk("R10 busy low after release", !busy && cs_line == 3'b111, {busy, cs_line}, 4'b0111);
  endtask

  task automatic t_mid_change();
    int g;
    cfg_div = 6'd2;
    send(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1);
    wait_done(g);
    chk("R8 cs kept between bytes", cs_line == 3'b101 && tx_ready, cs_line, 3'b101);
    cfg_div = 6'd5;
    send(8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    wait_done(g);
    chk("R1 divisor held in transfer", (rt1 - rt0) == 48, rt1 - rt0, 48);
    chk("R9 gap after multi-byte", g == GAP_CYC, g, GAP_CYC);
  endtask

  task automatic t_polarity();
    int g;
    cs_pol_hi = 3'b010;
    repeat (2) @(negedge clk);
    chk("R7 idle high-pol line low", cs_line == 3'b101, cs_line, 3'b101);
    cfg_div = 6'd1;
    send(8'hC3, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1);
    wait_first_rise();
    chk("R7 high-pol asserted", cs_line == 3'b111, cs_line, 3'b111);
    wait_done(g);
    chk("R7 high-pol released", cs_line == 3'b101, cs_line, 3'b101);
    cs_pol_hi = 3'b000;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_single();
    t_dual();
    t_div_zero();
    t_blank();
    t_hold();
    t_mid_change();
    t_polarity();
    repeat (5) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule